// File: doc/BRIEF.md
# PC Card Configuration Register Block

This block is the card-side set of four byte-wide configuration registers that a host reaches through attribute-memory space on an ATA-class removable card. The host selects one register with a two-bit selector, then writes it or reads it back. The block uses the register contents to drive card-wide controls: a soft reset, the addressing mode the card answers in, and whether interrupts are level or pulse style. It also drives the active-low status-change line.

The rest of the card supplies four inputs: its ready/busy state, its raw interrupt request, the interrupt-disable bit held in the ATA device-control register, and an acknowledge that tells which power state the card is actually in. The drive bit of the ATA drive/head register is also an input. The block compares it with the stored copy number and reports whether this card is the one addressed.

There are cross-register side effects. The ready-change flag sets by itself whenever the reported ready state flips. A power-state request holds the card busy until the acknowledge arrives. The status-change line needs three conditions at once.

Top module: `pccard_cfg_regs`

## Requirements
- R1: The register selector maps 0 to the option register, 1 to the status register, 2 to the pin register and 3 to the socket register. A read returns its byte on `host_rdata` on the clock after the strobe. After `rst` the option, status and socket registers read 0x00, and the pin register reads 0x0C with bit 1 set to `core_ready`.
- R2: Outside soft reset, an option-register write stores bit 6 as the level-interrupt flag and bits 5:0 as the mode index. Both read back exactly as written, and `irq_level_mode` equals bit 6.
- R3: `addr_mode` is 1 for index 1 (contiguous I/O), 2 for index 2 (primary I/O) and 3 for index 3 (secondary I/O). It is 0 (memory mapped) for index 0 and for every index above 3.
- R4: Writing option bit 7 as 1 raises `soft_rst` from the next clock. It clears the index, the level flag, the status register, the ready-change flag and any pending power busy. While `soft_rst` is high, option-register writes change only bit 7 and status-register writes are ignored. Writing bit 7 as 0 drops `soft_rst` and leaves index 0 and level flag 0, whatever the other written bits are. The socket register keeps its value.
- R5: The status register reads as {ready-change flag, status-change enable, 0, 0, 0, power-down request, interrupt, 0}. Bit 5 accepts writes but always reads 0. Bit 7 cannot be written through this register.
- R6: Status bit 1 reads `core_irq` AND NOT `irq_disable`.
- R7: The pin register reads as {0, 0, ready-change flag, 0, 1, 1, ready, 0}. The ready bit is `core_ready` while no power-state change is pending, and 0 while one is pending.
- R8: The ready-change flag sets on the clock after the ready bit differs from its value one clock earlier. This set takes priority over a host write in the same clock.
- R9: A pin-register write updates the ready-change flag from bit 5 only when bit 1 of the written byte is 1. Otherwise the flag is unchanged.
- R10: A status write that flips the power-down bit makes the ready bit read 0 from the next clock. It stays 0 until `pwr_is_down` equals the requested value, and returns one clock after that match is seen.
- R11: `stschg_n` is 0 only when the ready-change flag is 1, the status-change enable is 1 and `addr_mode` is non-zero. It is 1 in every other case.
- R12: The interrupt source is `core_irq` AND NOT `irq_disable`. In level mode `irq_n` equals the inverted source one clock later. In pulse mode each rising edge of the source makes `irq_n` low for exactly IRQ_PULSE_CYC clocks, starting one clock after the edge.
- R13: The socket register stores bits 6:4 as the copy number and bits 3:0 as the socket number, and bit 7 reads 0. `card_selected` is 1 exactly when the copy number equals `drive_bit` zero-extended to three bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| host_en | input | 1 | One-clock register access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_sel | input | 2 | Register selector |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Registered read byte |
| core_ready | input | 1 | Card core ready (1) or busy (0) |
| core_irq | input | 1 | Raw interrupt request from the core |
| irq_disable | input | 1 | Interrupt-disable bit of the ATA device-control register |
| pwr_is_down | input | 1 | Acknowledged power state, 1 = powered down |
| drive_bit | input | 1 | Drive bit of the ATA drive/head register |
| soft_rst | output | 1 | Soft reset to the rest of the card |
| addr_mode | output | 2 | Decoded addressing mode |
| irq_level_mode | output | 1 | 1 = level interrupts, 0 = pulse interrupts |
| irq_n | output | 1 | Active-low shaped interrupt |
| stschg_n | output | 1 | Active-low status-change output |
| card_selected | output | 1 | This card matches the addressed drive |

## Verification
The bench builds the block with IRQ_PULSE_CYC set to 2, not the default of 1. A pulse that spans more than one clock shows that the width counter, and not just an edge detector, sets the low time.

Every byte is swept through the option and socket registers, and every non-power byte through the status register. All combinations of ready-change flag, enable and representative index values are driven into the status-change output.

Directed sequences cover the rest:
- the power-acknowledge handshake;
- the masked flag write;
- a ready change colliding with a clearing write;
- the soft-reset entry and exit paths.

// File: rtl/pcc_cfg_pkg.sv
package pcc_cfg_pkg;

    localparam int REG_W   = 8;
    localparam int INDEX_W = 6;
    localparam int COPY_W  = 3;
    localparam int SOCK_W  = 4;

    typedef enum logic [1:0] {
        MODE_MEM          = 2'd0,
        MODE_IO_CONTIG    = 2'd1,
        MODE_IO_PRIMARY   = 2'd2,
        MODE_IO_SECONDARY = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        SEL_OPTION = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_PINREP = 2'd2,
        SEL_SOCKET = 2'd3
    } reg_sel_e;

    // Bit positions inside the register bytes
    localparam int OPT_SRST_BIT  = 7;
    localparam int OPT_LEVEL_BIT = 6;
    localparam int STS_SIGCHG    = 6;
    localparam int STS_PWRDWN    = 2;
    localparam int PIN_CREADY    = 5;
    localparam int PIN_MASK      = 1;

    typedef struct packed {
        logic       sreset;
        logic       level;
        logic [INDEX_W-1:0] index;
    } opt_reg_t;

    function automatic addr_mode_e decode_index(input logic [INDEX_W-1:0] idx);
        case (idx)
            6'd1:    return MODE_IO_CONTIG;
            6'd2:    return MODE_IO_PRIMARY;
            6'd3:    return MODE_IO_SECONDARY;
            default: return MODE_MEM;
        endcase
    endfunction

endpackage

// File: rtl/pcc_opt_reg.sv
module pcc_opt_reg
    import pcc_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output opt_reg_t         opt_q,
    output addr_mode_e       mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            opt_q <= '0;
        end else if (wr_en) begin
            if (wdata[OPT_SRST_BIT] || opt_q.sreset) begin
                // entering or leaving soft reset: configuration forced clear
                opt_q.sreset <= wdata[OPT_SRST_BIT];
                opt_q.level  <= 1'b0;
                opt_q.index  <= '0;
            end else begin
                opt_q.level  <= wdata[OPT_LEVEL_BIT];
                opt_q.index  <= wdata[INDEX_W-1:0];
            end
        end
    end

    assign mode = decode_index(opt_q.index);
endmodule

// File: rtl/pcc_ready_track.sv
module pcc_ready_track (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic core_ready,
    input  logic pwr_is_down,
    input  logic pwrdwn_q,
    input  logic pwr_chg,
    input  logic pin_wr,
    input  logic pin_mask,
    input  logic pin_cready,
    output logic rready,
    output logic cready,
    output logic pwr_busy
);
    logic rready_prev;

    assign rready = core_ready & ~pwr_busy;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pwr_busy <= 1'b0;
        end else if (pwr_chg) begin
            pwr_busy <= 1'b1;
        end else if (pwr_busy && (pwr_is_down == pwrdwn_q)) begin
            pwr_busy <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        rready_prev <= rready;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cready <= 1'b0;
        end else if (rready != rready_prev) begin
            cready <= 1'b1;
        end else if (pin_wr && pin_mask) begin
            cready <= pin_cready;
        end
    end
endmodule

// File: rtl/pcc_irq_shaper.sv
module pcc_irq_shaper #(
    parameter int IRQ_PULSE_CYC = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic level_mode,
    input  logic src,
    output logic irq_n
);
    localparam int CNT_W = $clog2(IRQ_PULSE_CYC + 1);

    logic             src_prev;
    logic             lvl_q;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            src_prev <= 1'b0;
            lvl_q    <= 1'b0;
            cnt      <= '0;
        end else begin
            src_prev <= src;
            lvl_q    <= src;
            if (src && !src_prev && !level_mode) begin
                cnt <= CNT_W'(IRQ_PULSE_CYC);
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign irq_n = level_mode ? ~lvl_q : (cnt == '0);
endmodule

// File: rtl/pccard_cfg_regs.sv
module pccard_cfg_regs
    import pcc_cfg_pkg::*;
#(
    parameter int IRQ_PULSE_CYC = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_en,
    input  logic       host_wr,
    input  logic [1:0] host_sel,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       core_ready,
    input  logic       core_irq,
    input  logic       irq_disable,
    input  logic       pwr_is_down,
    input  logic       drive_bit,
    output logic       soft_rst,
    output logic [1:0] addr_mode,
    output logic       irq_level_mode,
    output logic       irq_n,
    output logic       stschg_n,
    output logic       card_selected
);
    opt_reg_t          opt_q;
    addr_mode_e        mode;
    logic              wr_opt, wr_sts, wr_pin, wr_sock, rd_any;
    logic              sigchg_q, pwrdwn_q, pwr_chg;
    logic              rready, cready, pwr_busy;
    logic              irq_src;
    logic [COPY_W-1:0] copy_q;
    logic [SOCK_W-1:0] sock_q;

    assign wr_opt  = host_en && host_wr && (host_sel == SEL_OPTION);
    assign wr_sts  = host_en && host_wr && (host_sel == SEL_STATUS);
    assign wr_pin  = host_en && host_wr && (host_sel == SEL_PINREP);
    assign wr_sock = host_en && host_wr && (host_sel == SEL_SOCKET);
    assign rd_any  = host_en && !host_wr;

    pcc_opt_reg u_opt (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_opt),
        .wdata (host_wdata),
        .opt_q (opt_q),
        .mode  (mode)
    );

    assign soft_rst       = opt_q.sreset;
    assign addr_mode      = mode;
    assign irq_level_mode = opt_q.level;

    // Status register: enable and power request
    assign pwr_chg = wr_sts && !soft_rst && (host_wdata[STS_PWRDWN] != pwrdwn_q);

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            sigchg_q <= 1'b0;
            pwrdwn_q <= 1'b0;
        end else if (wr_sts) begin
            sigchg_q <= host_wdata[STS_SIGCHG];
            pwrdwn_q <= host_wdata[STS_PWRDWN];
        end
    end

    pcc_ready_track u_rdy (
        .clk         (clk),
        .rst         (rst),
        .clr         (soft_rst),
        .core_ready  (core_ready),
        .pwr_is_down (pwr_is_down),
        .pwrdwn_q    (pwrdwn_q),
        .pwr_chg     (pwr_chg),
        .pin_wr      (wr_pin),
        .pin_mask    (host_wdata[PIN_MASK]),
        .pin_cready  (host_wdata[PIN_CREADY]),
        .rready      (rready),
        .cready      (cready),
        .pwr_busy    (pwr_busy)
    );

    assign irq_src = core_irq & ~irq_disable;

    pcc_irq_shaper #(.IRQ_PULSE_CYC(IRQ_PULSE_CYC)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .clr        (soft_rst),
        .level_mode (opt_q.level),
        .src        (irq_src),
        .irq_n      (irq_n)
    );

    // Socket and copy register survives soft reset
    always_ff @(posedge clk) begin
        if (rst) begin
            copy_q <= '0;
            sock_q <= '0;
        end else if (wr_sock) begin
            copy_q <= host_wdata[SOCK_W+COPY_W-1:SOCK_W];
            sock_q <= host_wdata[SOCK_W-1:0];
        end
    end

    assign card_selected = (copy_q == {{(COPY_W-1){1'b0}}, drive_bit});
    assign stschg_n      = ~(cready & sigchg_q & (mode != MODE_MEM));

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata <= '0;
        end else if (rd_any) begin
            case (reg_sel_e'(host_sel))
                SEL_OPTION: host_rdata <= opt_q;
                SEL_STATUS: host_rdata <= {cready, sigchg_q, 3'b000, pwrdwn_q, irq_src, 1'b0};
                SEL_PINREP: host_rdata <= {2'b00, cready, 1'b0, 2'b11, rready, 1'b0};
                default:    host_rdata <= {1'b0, copy_q, sock_q};
            endcase
        end
    end
endmodule

// File: rtl/pccard_cfg_regs_chk.sv
module pccard_cfg_regs_chk (
    input logic       clk,
    input logic       rst,
    input logic       soft_rst,
    input logic [1:0] addr_mode,
    input logic       irq_level_mode,
    input logic       irq_n,
    input logic       irq_disable,
    input logic       stschg_n,
    input logic       rready,
    input logic       cready,
    input logic       pwr_busy,
    input logic       pwr_is_down,
    input logic       pwrdwn_q
);
    AST_SRST_MEM: assert property (@(posedge clk) disable iff (rst)
        soft_rst |-> (addr_mode == 2'd0) && !irq_level_mode); // R4

    AST_STSCHG_IO: assert property (@(posedge clk) disable iff (rst)
        !stschg_n |-> (addr_mode != 2'd0) && cready); // R11

    AST_CREADY_SET: assert property (@(posedge clk) disable iff (rst)
        (rready != $past(rready)) && !soft_rst |=> cready); // R8

    AST_PWR_HOLD: assert property (@(posedge clk) disable iff (rst)
        pwr_busy && (pwr_is_down != pwrdwn_q) && !soft_rst |=> !rready); // R10

    AST_LVL_MASK: assert property (@(posedge clk) disable iff (rst)
        irq_level_mode && $past(irq_level_mode) && $past(irq_disable) |-> irq_n); // R12
endmodule

bind pccard_cfg_regs pccard_cfg_regs_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .soft_rst       (soft_rst),
    .addr_mode      (addr_mode),
    .irq_level_mode (irq_level_mode),
    .irq_n          (irq_n),
    .irq_disable    (irq_disable),
    .stschg_n       (stschg_n),
    .rready         (rready),
    .cready         (cready),
    .pwr_busy       (pwr_busy),
    .pwr_is_down    (pwr_is_down),
    .pwrdwn_q       (pwrdwn_q)
);

// File: tb/pccard_cfg_regs_tb.sv
`timescale 1ns/1ps
module pccard_cfg_regs_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_en = 1'b0, host_wr = 1'b0;
    logic [1:0] host_sel = 2'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       core_ready = 1'b1, core_irq = 1'b0, irq_disable = 1'b0;
    logic       pwr_is_down = 1'b0, drive_bit = 1'b0;
    logic       soft_rst, irq_level_mode, irq_n, stschg_n, card_selected;
    logic [1:0] addr_mode;

    int checks = 0;
    int failures = 0;
    logic [7:0] rv;

    always #4 clk = ~clk;

    pccard_cfg_regs #(.IRQ_PULSE_CYC(2)) u_dut (
        .clk(clk), .rst(rst), .host_en(host_en), .host_wr(host_wr),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .core_ready(core_ready), .core_irq(core_irq), .irq_disable(irq_disable),
        .pwr_is_down(pwr_is_down), .drive_bit(drive_bit), .soft_rst(soft_rst),
        .addr_mode(addr_mode), .irq_level_mode(irq_level_mode), .irq_n(irq_n),
        .stschg_n(stschg_n), .card_selected(card_selected)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int data);
        @(negedge clk);
        host_en = 1'b1; host_wr = 1'b1; host_sel = sel[1:0]; host_wdata = data[7:0];
        @(negedge clk);
        host_en = 1'b0; host_wr = 1'b0;
    endtask

    task automatic rd(input int sel, output logic [7:0] val);
        @(negedge clk);
        host_en = 1'b1; host_wr = 1'b0; host_sel = sel[1:0];
        @(negedge clk);
        host_en = 1'b0;
        val = host_rdata;
    endtask

    function automatic int mode_of(input int idx);
        return (idx >= 1 && idx <= 3) ? idx : 0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(0, rv); chk("R1 option reset", rv, 8'h00);
        rd(1, rv); chk("R1 status reset", rv, 8'h00);
        rd(2, rv); chk("R1 pin reset", rv, 8'h0E);
        rd(3, rv); chk("R1 socket reset", rv, 8'h00);
        chk("R1 soft_rst reset", soft_rst, 0);
        chk("R11 stschg_n reset", stschg_n, 1);
        chk("R12 irq_n reset", irq_n, 1);

        // R2 R3 option sweep
        for (int v = 0; v < 128; v++) begin
            wr(0, v);
            chk("R3 addr_mode", addr_mode, mode_of(v & 63));
            chk("R2 level flag", irq_level_mode, (v >> 6) & 1);
            rd(0, rv); chk("R2 option readback", rv, v);
        end
        wr(0, 0);

        // R13 socket sweep and selection
        for (int v = 0; v < 256; v++) begin
            wr(3, v);
            rd(3, rv); chk("R13 socket readback", rv, v & 8'h7F);
            for (int d = 0; d < 2; d++) begin
                drive_bit = d[0];
                #1;
                chk("R13 card_selected", card_selected, (((v >> 4) & 7) == d) ? 1 : 0);
            end
        end
        wr(3, 0);

        // R5 status sweep without the power bit
        for (int v = 0; v < 256; v++) begin
            if ((v & 4) == 0) begin
                wr(1, v);
                rd(1, rv); chk("R5 status layout", rv, v & 8'h40);
            end
        end
        wr(1, 0);

        // R6 interrupt bit
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            core_irq = c[0]; irq_disable = c[1];
            rd(1, rv); chk("R6 intr bit", rv, (c == 1) ? 2 : 0);
        end
        @(negedge clk); core_irq = 0; irq_disable = 0;
        repeat (4) @(negedge clk);

        // R10 power-down handshake
        wr(1, 8'h04);
        rd(2, rv); chk("R10 busy after request", rv, 8'h2C);
        repeat (5) @(negedge clk);
        rd(2, rv); chk("R10 busy holds", rv, 8'h2C);
        wr(2, 8'h02);
        rd(2, rv); chk("R9 masked clear", rv, 8'h0C);
        @(negedge clk); pwr_is_down = 1'b1;
        repeat (2) @(negedge clk);
        rd(2, rv); chk("R10 ready after ack", rv, 8'h2E);
        rd(1, rv); chk("R5 changed mirrors flag", rv, 8'h84);
        wr(1, 8'h00);
        @(negedge clk); pwr_is_down = 1'b0;
        repeat (3) @(negedge clk);
        wr(2, 8'h02);
        wr(1, 8'h00);
        rd(2, rv); chk("R10 unchanged request no busy", rv, 8'h0E);

        // R9 masked writes
        wr(2, 8'h20); rd(2, rv); chk("R9 mask off set", rv, 8'h0E);
        wr(2, 8'h22); rd(2, rv); chk("R9 mask on set", rv, 8'h2E);
        wr(2, 8'h20); rd(2, rv); chk("R9 mask off clear", rv, 8'h2E);
        wr(2, 8'h02); rd(2, rv); chk("R9 mask on clear", rv, 8'h0E);

        // R7 R8 core ready change
        @(negedge clk); core_ready = 1'b0;
        repeat (2) @(negedge clk);
        rd(2, rv); chk("R8 flag on ready drop", rv, 8'h2C);
        wr(2, 8'h02);
        rd(2, rv); chk("R7 busy core", rv, 8'h0C);
        @(negedge clk);
        core_ready = 1'b1;
        host_en = 1'b1; host_wr = 1'b1; host_sel = 2'd2; host_wdata = 8'h02;
        @(negedge clk);
        host_en = 1'b0; host_wr = 1'b0;
        rd(2, rv); chk("R8 set beats write", rv, 8'h2E);
        wr(2, 8'h02);

        // R11 status-change sweep
        for (int cr = 0; cr < 2; cr++) begin
            for (int sg = 0; sg < 2; sg++) begin
                for (int k = 0; k < 6; k++) begin
                    int idx;
                    idx = (k < 4) ? k : ((k == 4) ? 4 : 63);
                    wr(2, (cr << 5) | 2);
                    wr(1, sg << 6);
                    wr(0, idx);
                    chk("R11 stschg_n", stschg_n,
                        (cr == 1 && sg == 1 && mode_of(idx) != 0) ? 0 : 1);
                end
            end
        end
        wr(2, 8'h02); wr(1, 0); wr(0, 0);

        // R12 level mode
        wr(0, 8'h41);
        @(negedge clk); core_irq = 1'b1;
        @(negedge clk); chk("R12 level asserted", irq_n, 0);
        repeat (3) @(negedge clk); chk("R12 level held", irq_n, 0);
        irq_disable = 1'b1;
        @(negedge clk); chk("R12 level masked", irq_n, 1);
        core_irq = 1'b0; irq_disable = 1'b0;
        @(negedge clk); chk("R12 level released", irq_n, 1);

        // R12 pulse mode, width 2
        wr(0, 8'h01);
        repeat (2) @(negedge clk);
        core_irq = 1'b1;
        @(negedge clk); chk("R12 pulse cycle1", irq_n, 0);
        @(negedge clk); chk("R12 pulse cycle2", irq_n, 0);
        @(negedge clk); chk("R12 pulse ends", irq_n, 1);
        @(negedge clk); chk("R12 pulse no repeat", irq_n, 1);
        core_irq = 1'b0; irq_disable = 1'b1;
        @(negedge clk); core_irq = 1'b1;
        @(negedge clk); chk("R12 pulse masked", irq_n, 1);
        @(negedge clk); core_irq = 1'b0; irq_disable = 1'b0;

        // R4 soft reset
        wr(0, 8'h42);
        wr(1, 8'h40);
        wr(2, 8'h22);
        wr(3, 8'h35);
        chk("R11 configured low", stschg_n, 0);
        wr(0, 8'h80);
        chk("R4 soft_rst high", soft_rst, 1);
        chk("R4 mode memory", addr_mode, 0);
        chk("R4 level cleared", irq_level_mode, 0);
        chk("R4 stschg released", stschg_n, 1);
        wr(0, 8'hC3);
        rd(0, rv); chk("R4 index write ignored", rv, 8'h80);
        wr(1, 8'h44);
        rd(1, rv); chk("R4 status cleared", rv, 8'h00);
        rd(3, rv); chk("R4 socket kept", rv, 8'h35);
        wr(0, 8'h43);
        chk("R4 soft_rst low", soft_rst, 0);
        rd(0, rv); chk("R4 exit unconfigured", rv, 8'h00);
        rd(2, rv); chk("R4 flag cleared", rv, 8'h0E);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule